// File: doc/BRIEF.md
# Banked CPU Register File

This block is the architectural register storage of a small 8-bit processor core. It keeps an accumulator/flags pair, three general pairs (BC, DE, HL), two 16-bit index registers (IX, IY), the stack pointer and the program counter. AF, BC, DE and HL each also have a shadow copy. The decoder outside reads single bytes by a 3-bit operand code or whole pairs by a 3-bit pair select, and it can write one of the two each cycle. Reads are combinational. Writes and swaps take effect on the rising clock edge.

There are two swap commands. One exchanges AF with its shadow. The other exchanges BC, DE and HL with theirs. No data moves during a swap. Each group has a small two-state machine that names which copy is live. Its states are `BANK_MAIN` and `BANK_SHADOW`. The transition `SWAP_TO_SHADOW` goes from `BANK_MAIN` to `BANK_SHADOW`, and `SWAP_TO_MAIN` goes back. Each is taken on a clock edge where that group's swap input is high. Without a swap the state holds.

A 2-bit prefix input lets the decoder point the H and L operand codes at the halves of an index register instead. This is how index-prefixed instructions reach the index bytes.

Top module: `regfile`

## Requirements
- R1: After reset, AF and shadow AF read 0xFFFF and SP reads 0xFFFF. BC, DE, HL, their shadows, IX, IY and PC read 0x0000.
- R2: 8-bit operand codes are B=0, C=1, D=2, E=3, H=4, L=5, A=7, where A is the high byte of AF. A write to a code updates only that byte, and a read returns it. Code 6 reads 0x00, and a write to code 6 changes no register.
- R3: Pair select codes are BC=0, DE=1, HL=2, AF=3, IX=4, IY=5, SP=6, PC=7. A 16-bit write stores the whole pair, and a 16-bit read returns it.
- R4: A swap-AF pulse exchanges the live AF with its shadow and leaves every other register as it was. A second pulse restores the original.
- R5: A swap-general pulse exchanges BC, DE and HL with their shadows. AF, IX, IY, SP and PC are left as they were.
- R6: Prefix 2'b01 maps codes 4 and 5 to the high and low bytes of IX. Prefix 2'b10 maps them to the high and low bytes of IY. This applies to both reads and writes. Prefixes 2'b00 and 2'b11 leave them on H and L.
- R7: The prefix has no effect on codes 0 to 3 and 7, and none on 16-bit selects.
- R8: A write in the same cycle as a swap lands in the copy that was live before the swap.
- R9: If an 8-bit and a 16-bit write are requested in the same cycle, only the 16-bit write takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| prefix_i | input | 2 | Index prefix: 01 selects IX, 10 selects IY, otherwise none |
| rd8_code_i | input | 3 | 8-bit read operand code |
| rd8_data_o | output | 8 | 8-bit read data |
| wr8_en_i | input | 1 | 8-bit write enable |
| wr8_code_i | input | 3 | 8-bit write operand code |
| wr8_data_i | input | 8 | 8-bit write data |
| rd16_sel_i | input | 3 | Pair read select |
| rd16_data_o | output | 16 | Pair read data |
| wr16_en_i | input | 1 | Pair write enable |
| wr16_sel_i | input | 3 | Pair write select |
| wr16_data_i | input | 16 | Pair write data |
| swap_af_i | input | 1 | Exchange AF with its shadow |
| swap_gen_i | input | 1 | Exchange BC, DE and HL with their shadows |

## Verification
The checks on the swap state machines assume that each swap input is a single-cycle level sampled at the clock edge. The stimulus raises each swap for exactly one cycle, sometimes both together and sometimes alongside a write. The properties on the index byte write and on the stable PC and SP depend on the absence of a competing 16-bit write. The stimulus issues 8-bit writes alone, except in the one cycle set aside to test write precedence. The sweeps cover every prefix value with every operand code, so the reserved prefix 2'b11 and the unused code 6 are both driven.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
    typedef enum logic {
        BANK_MAIN   = 1'b0,
        BANK_SHADOW = 1'b1
    } bank_e;

    localparam int NSLOT   = 8;
    localparam int NBANKED = 4;

    localparam logic [2:0] SLOT_BC = 3'd0;
    localparam logic [2:0] SLOT_DE = 3'd1;
    localparam logic [2:0] SLOT_HL = 3'd2;
    localparam logic [2:0] SLOT_AF = 3'd3;
    localparam logic [2:0] SLOT_IX = 3'd4;
    localparam logic [2:0] SLOT_IY = 3'd5;
    localparam logic [2:0] SLOT_SP = 3'd6;
    localparam logic [2:0] SLOT_PC = 3'd7;

    localparam logic [2:0] OP_B = 3'd0;
    localparam logic [2:0] OP_C = 3'd1;
    localparam logic [2:0] OP_D = 3'd2;
    localparam logic [2:0] OP_E = 3'd3;
    localparam logic [2:0] OP_H = 3'd4;
    localparam logic [2:0] OP_L = 3'd5;
    localparam logic [2:0] OP_A = 3'd7;

    localparam logic [1:0] PFX_IX = 2'b01;
    localparam logic [1:0] PFX_IY = 2'b10;
endpackage

// File: rtl/bank_fsm.sv
module bank_fsm
    import regfile_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  swap_i,
    output bank_e bank_o
);
    bank_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BANK_MAIN:   if (swap_i) state_d = BANK_SHADOW;  // SWAP_TO_SHADOW
            BANK_SHADOW: if (swap_i) state_d = BANK_MAIN;    // SWAP_TO_MAIN
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BANK_MAIN;
        else        state_q <= state_d;
    end

    always_comb bank_o = state_q;
endmodule

// File: rtl/pair_reg.sv
module pair_reg #(
    parameter int BYTE_W = 8,
    parameter logic [2*BYTE_W-1:0] RST_VAL = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we_hi,
    input  logic                we_lo,
    input  logic [2*BYTE_W-1:0] din,
    output logic [2*BYTE_W-1:0] q
);
    localparam int PAIR_W = 2 * BYTE_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else begin
            if (we_hi) q[PAIR_W-1:BYTE_W] <= din[PAIR_W-1:BYTE_W];
            if (we_lo) q[BYTE_W-1:0]      <= din[BYTE_W-1:0];
        end
    end
endmodule

// File: rtl/regfile.sv
module regfile
    import regfile_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          prefix_i,
    input  logic [2:0]          rd8_code_i,
    output logic [BYTE_W-1:0]   rd8_data_o,
    input  logic                wr8_en_i,
    input  logic [2:0]          wr8_code_i,
    input  logic [BYTE_W-1:0]   wr8_data_i,
    input  logic [2:0]          rd16_sel_i,
    output logic [2*BYTE_W-1:0] rd16_data_o,
    input  logic                wr16_en_i,
    input  logic [2:0]          wr16_sel_i,
    input  logic [2*BYTE_W-1:0] wr16_data_i,
    input  logic                swap_af_i,
    input  logic                swap_gen_i
);
    localparam int PAIR_W = 2 * BYTE_W;

    bank_e             af_bank, gen_bank;
    logic [PAIR_W-1:0] slot_q [NSLOT];
    logic [NSLOT-1:0]  we_hi, we_lo;
    logic [PAIR_W-1:0] wdata;
    logic [2:0]        hl_slot;

    bank_fsm u_af_bank  (.clk(clk), .rst_n(rst_n), .swap_i(swap_af_i),  .bank_o(af_bank));
    bank_fsm u_gen_bank (.clk(clk), .rst_n(rst_n), .swap_i(swap_gen_i), .bank_o(gen_bank));

    // H/L operand codes follow the prefix onto an index register
    always_comb begin
        unique case (prefix_i)
            PFX_IX:  hl_slot = SLOT_IX;
            PFX_IY:  hl_slot = SLOT_IY;
            default: hl_slot = SLOT_HL;
        endcase
    end

    // Write decode: a pair write wins over a byte write
    always_comb begin
        we_hi = '0;
        we_lo = '0;
        wdata = {wr8_data_i, wr8_data_i};
        if (wr16_en_i) begin
            we_hi[wr16_sel_i] = 1'b1;
            we_lo[wr16_sel_i] = 1'b1;
            wdata = wr16_data_i;
        end else if (wr8_en_i) begin
            case (wr8_code_i)
                OP_B:    we_hi[SLOT_BC] = 1'b1;
                OP_C:    we_lo[SLOT_BC] = 1'b1;
                OP_D:    we_hi[SLOT_DE] = 1'b1;
                OP_E:    we_lo[SLOT_DE] = 1'b1;
                OP_H:    we_hi[hl_slot] = 1'b1;
                OP_L:    we_lo[hl_slot] = 1'b1;
                OP_A:    we_hi[SLOT_AF] = 1'b1;
                default: ;
            endcase
        end
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        localparam logic [PAIR_W-1:0] RV =
            (s == int'(SLOT_AF) || s == int'(SLOT_SP)) ? {PAIR_W{1'b1}} : {PAIR_W{1'b0}};
        if (s < NBANKED) begin : g_banked
            logic              live_shadow;
            logic [PAIR_W-1:0] q_bank [2];
            assign live_shadow = (s == int'(SLOT_AF)) ? (af_bank == BANK_SHADOW)
                                                      : (gen_bank == BANK_SHADOW);
            for (genvar b = 0; b < 2; b++) begin : g_copy
                logic sel_b;
                assign sel_b = (live_shadow == (b == 1));
                pair_reg #(.BYTE_W(BYTE_W), .RST_VAL(RV)) u_pair (
                    .clk(clk), .rst_n(rst_n),
                    .we_hi(we_hi[s] && sel_b), .we_lo(we_lo[s] && sel_b),
                    .din(wdata), .q(q_bank[b])
                );
            end
            assign slot_q[s] = live_shadow ? q_bank[1] : q_bank[0];
        end else begin : g_single
            pair_reg #(.BYTE_W(BYTE_W), .RST_VAL(RV)) u_pair (
                .clk(clk), .rst_n(rst_n),
                .we_hi(we_hi[s]), .we_lo(we_lo[s]),
                .din(wdata), .q(slot_q[s])
            );
        end
    end

    assign rd16_data_o = slot_q[rd16_sel_i];

    always_comb begin
        case (rd8_code_i)
            OP_B:    rd8_data_o = slot_q[SLOT_BC][PAIR_W-1:BYTE_W];
            OP_C:    rd8_data_o = slot_q[SLOT_BC][BYTE_W-1:0];
            OP_D:    rd8_data_o = slot_q[SLOT_DE][PAIR_W-1:BYTE_W];
            OP_E:    rd8_data_o = slot_q[SLOT_DE][BYTE_W-1:0];
            OP_H:    rd8_data_o = slot_q[hl_slot][PAIR_W-1:BYTE_W];
            OP_L:    rd8_data_o = slot_q[hl_slot][BYTE_W-1:0];
            OP_A:    rd8_data_o = slot_q[SLOT_AF][PAIR_W-1:BYTE_W];
            default: rd8_data_o = '0;
        endcase
    end
endmodule

// File: rtl/regfile_chk.sv
module regfile_chk
    import regfile_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          prefix_i,
    input logic                wr8_en_i,
    input logic [2:0]          wr8_code_i,
    input logic [BYTE_W-1:0]   wr8_data_i,
    input logic                wr16_en_i,
    input logic                swap_af_i,
    input logic                swap_gen_i,
    input bank_e               af_bank,
    input bank_e               gen_bank,
    input logic [2*BYTE_W-1:0] ix_val,
    input logic [2*BYTE_W-1:0] sp_val,
    input logic [2*BYTE_W-1:0] pc_val
);
    assert_af_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        swap_af_i |=> af_bank != $past(af_bank));

    assert_af_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !swap_af_i |=> $stable(af_bank));

    assert_gen_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        swap_gen_i |=> gen_bank != $past(gen_bank));

    assert_gen_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !swap_gen_i |=> $stable(gen_bank));

    assert_spc_untouched_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_gen_i && !wr8_en_i && !wr16_en_i) |=> ($stable(sp_val) && $stable(pc_val)));

    assert_ix_hi_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr8_en_i && !wr16_en_i && wr8_code_i == OP_H && prefix_i == PFX_IX)
        |=> ix_val[2*BYTE_W-1:BYTE_W] == $past(wr8_data_i));
endmodule

bind regfile regfile_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .prefix_i(prefix_i),
    .wr8_en_i(wr8_en_i), .wr8_code_i(wr8_code_i), .wr8_data_i(wr8_data_i),
    .wr16_en_i(wr16_en_i), .swap_af_i(swap_af_i), .swap_gen_i(swap_gen_i),
    .af_bank(af_bank), .gen_bank(gen_bank),
    .ix_val(slot_q[4]), .sp_val(slot_q[6]), .pc_val(slot_q[7])
);

// File: tb/sim_regfile.sv
`timescale 1ns/1ps
module sim_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  prefix_i = '0;
    logic [2:0]  rd8_code_i = '0;
    logic [7:0]  rd8_data_o;
    logic        wr8_en_i = 1'b0;
    logic [2:0]  wr8_code_i = '0;
    logic [7:0]  wr8_data_i = '0;
    logic [2:0]  rd16_sel_i = '0;
    logic [15:0] rd16_data_o;
    logic        wr16_en_i = 1'b0;
    logic [2:0]  wr16_sel_i = '0;
    logic [15:0] wr16_data_i = '0;
    logic        swap_af_i = 1'b0;
    logic        swap_gen_i = 1'b0;

    int checks = 0;
    int errors = 0;
    logic [15:0] m_cur [8];
    logic [15:0] m_alt [4];

    always #10 clk = ~clk;

    regfile u0 (.*);

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    function automatic int hslot(input logic [1:0] p);
        return (p == 2'b01) ? 4 : (p == 2'b10) ? 5 : 2;
    endfunction

    function automatic logic [7:0] exp8(input logic [1:0] p, input int c);
        case (c)
            0: return m_cur[0][15:8];
            1: return m_cur[0][7:0];
            2: return m_cur[1][15:8];
            3: return m_cur[1][7:0];
            4: return m_cur[hslot(p)][15:8];
            5: return m_cur[hslot(p)][7:0];
            7: return m_cur[3][15:8];
            default: return 8'h00;
        endcase
    endfunction

    // One clock step: model updated write-first, then swaps (pre-swap bank gets the write)
    task automatic op(input logic w16, input int sel, input logic [15:0] d16,
                      input logic w8, input int code, input logic [7:0] d8,
                      input logic [1:0] p, input logic saf, input logic sgen);
        logic [15:0] t;
        wr16_en_i = w16; wr16_sel_i = 3'(sel); wr16_data_i = d16;
        wr8_en_i = w8; wr8_code_i = 3'(code); wr8_data_i = d8;
        prefix_i = p; swap_af_i = saf; swap_gen_i = sgen;
        if (w16) m_cur[sel] = d16;
        else if (w8) begin
            case (code)
                0: m_cur[0][15:8] = d8;
                1: m_cur[0][7:0] = d8;
                2: m_cur[1][15:8] = d8;
                3: m_cur[1][7:0] = d8;
                4: m_cur[hslot(p)][15:8] = d8;
                5: m_cur[hslot(p)][7:0] = d8;
                7: m_cur[3][15:8] = d8;
                default: ;
            endcase
        end
        if (saf) begin t = m_cur[3]; m_cur[3] = m_alt[3]; m_alt[3] = t; end
        if (sgen) for (int i = 0; i < 3; i++) begin
            t = m_cur[i]; m_cur[i] = m_alt[i]; m_alt[i] = t;
        end
        @(posedge clk);
        @(negedge clk);
        wr16_en_i = 0; wr8_en_i = 0; swap_af_i = 0; swap_gen_i = 0; prefix_i = 0;
    endtask

    task automatic check_pairs(input string tag);
        for (int s = 0; s < 8; s++) begin
            rd16_sel_i = 3'(s);
            #1;
            chk(tag, rd16_data_o, m_cur[s]);
        end
    endtask

    task automatic check_bytes;
        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 8; c++) begin
                prefix_i = 2'(p); rd8_code_i = 3'(c);
                #1;
                if (c == 4 || c == 5) chk("R6 byte read via prefix", {8'h0, rd8_data_o}, {8'h0, exp8(2'(p), c)});
                else if (c == 6)      chk("R2 code6 reads zero", {8'h0, rd8_data_o}, 16'h0);
                else                  chk("R7 byte read prefix-independent", {8'h0, rd8_data_o}, {8'h0, exp8(2'(p), c)});
            end
        end
        prefix_i = 0;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) m_cur[i] = (i == 3 || i == 6) ? 16'hFFFF : 16'h0000;
        for (int i = 0; i < 4; i++) m_alt[i] = (i == 3) ? 16'hFFFF : 16'h0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values, live and shadow
        check_pairs("R1 reset live");
        op(0, 0, 0, 0, 0, 0, 0, 1, 1);
        check_pairs("R1 reset shadow");
        op(0, 0, 0, 0, 0, 0, 0, 1, 1);

        // R3: every pair written and read back; prefix varied on reads for R7
        for (int s = 0; s < 8; s++) begin
            op(1, s, 16'(16'h1357 * (s + 1) + 16'h0101 * s), 0, 0, 0, 0, 0, 0);
            prefix_i = 2'(s % 4);
            check_pairs("R3 pair write/read");
        end

        // R2/R6/R7: every prefix with every byte code
        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 8; c++) begin
                op(0, 0, 0, 1, c, 8'(p * 37 + c * 11 + 5), 2'(p), 0, 0);
                check_pairs("R2 byte write effect");
                check_bytes();
            end
        end

        // R4: swap AF only, then restore
        op(0, 0, 0, 0, 0, 0, 0, 1, 0);
        check_pairs("R4 swap AF");
        op(0, 0, 0, 1, 7, 8'hA5, 0, 0, 0);
        check_pairs("R4 write shadow A");
        op(0, 0, 0, 0, 0, 0, 0, 1, 0);
        check_pairs("R4 swap AF back");

        // R5: swap general, write in shadow, swap back
        op(0, 0, 0, 0, 0, 0, 0, 0, 1);
        check_pairs("R5 swap general");
        op(1, 2, 16'hBEEF, 0, 0, 0, 0, 0, 0);
        op(0, 0, 0, 0, 0, 0, 0, 0, 1);
        check_pairs("R5 swap general back");

        // R8: write alongside swap lands in pre-swap copy
        op(0, 0, 0, 1, 0, 8'h3C, 0, 0, 1);
        check_pairs("R8 write with general swap");
        op(1, 3, 16'h7E81, 0, 0, 0, 0, 1, 0);
        check_pairs("R8 write with AF swap");
        op(0, 0, 0, 0, 0, 0, 0, 1, 1);
        check_pairs("R8 after swap back");

        // R9: pair write wins over byte write
        op(1, 1, 16'h4242, 1, 1, 8'h99, 0, 0, 0);
        check_pairs("R9 pair write precedence");
        check_bytes();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule